// File: doc/BRIEF.md
# Injected Sequence Context Queue

This block holds the setup for upcoming injected conversion sequences. A setup word carries the trigger edge choice, the trigger source choice, the sequence length and four channel numbers. Software may write setup words at any time, even while a sequence runs. Each word goes into a two-slot queue. The head slot is the active setup. It drives a sequencer, which reports each finished sequence with an end-of-sequence pulse.

When the queue is empty, a write takes effect on the next clock. Triggers are accepted whenever a setup is active. A write into a full queue is discarded. It raises a sticky overflow flag, which can also drive an interrupt. A mode input sets what happens when the sequencer finishes the last queued setup: the setup is either kept active, or the queue drains to empty and triggers are blocked. A flush input empties the queue at once.

Top module: `inj_ctx_queue`

## Requirements
- R1: The setup word is split as follows: bits [1:0] are the trigger edge, bits [5:2] are the trigger source and bits [7:6] are the sequence length. Channel k occupies bits [8+5k +: 5] for k = 0..3. The active setup appears on `act_edge`, `act_src`, `act_len` and `act_chan`, with channel k at `act_chan[5k +: 5]`.
- R2: After reset the queue is empty, `act_valid` is 0 and `ovf_flag` is 0.
- R3: A write into an empty queue becomes the active setup on the next cycle, and `act_valid` rises then.
- R4: A write while one setup is held is stored as pending, and the active setup does not change. On the next `eos` the pending setup becomes active one cycle later.
- R5: A write while two setups are held, with no `eos` in the same cycle, is discarded. The active setup stays unchanged and `ovf_flag` is set.
- R6: When `eos` and a write arrive in the same cycle on a full queue, the pop is applied first. The write is then stored as pending and no overflow is flagged.
- R7: `ovf_flag` stays set until an `ovf_clr` pulse. If an overflow and `ovf_clr` occur in the same cycle, the flag is set.
- R8: `ovf_irq` is high exactly when `ovf_flag` and `ovf_ie` are both high.
- R9: With `drain_mode` at 0, an `eos` while one setup is held keeps that setup active.
- R10: With `drain_mode` at 1, an `eos` while one setup is held empties the queue, and `act_valid` drops on the next cycle.
- R11: `flush` empties the queue in one cycle. A write in the same cycle as a flush becomes the only, active setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Setup word write strobe |
| wr_data | input | 28 | Setup word |
| eos | input | 1 | End of injected sequence from the sequencer |
| flush | input | 1 | Empty the queue |
| drain_mode | input | 1 | 0 keeps the last setup, 1 lets the queue drain |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| act_valid | output | 1 | A setup is active and triggers are accepted |
| act_edge | output | 2 | Active trigger edge |
| act_src | output | 4 | Active trigger source |
| act_len | output | 2 | Active sequence length |
| act_chan | output | 20 | Active channel numbers, 5 bits each |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach is a full queue that receives a write and an end-of-sequence pulse in the same cycle. Here the order of pop and push decides whether an overflow is flagged. The stimulus first fills both slots, clears the flag, and then drives both strobes in one cycle. A long random phase also produces this case often, with dense writes and end-of-sequence pulses. In that phase, a behavioural queue model is compared with the outputs on every clock.

// File: rtl/ictx_pkg.sv
package ictx_pkg;
    localparam int EDGE_W = 2;
    localparam int SRC_W  = 4;
    localparam int LEN_W  = 2;
    localparam int CH_W   = 5;
    localparam int NUM_CH = 4;
    localparam int CHAN_W = NUM_CH * CH_W;
    localparam int CTX_W  = EDGE_W + SRC_W + LEN_W + CHAN_W;
    localparam int FILL_W = 2;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [LEN_W-1:0]  len;
        logic [SRC_W-1:0]  src;
        logic [EDGE_W-1:0] edge_sel;
    } ctx_t;
endpackage

// File: rtl/ictx_store.sv
module ictx_store
    import ictx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  ctx_t              wr_ctx,
    input  logic              eos,
    input  logic              flush,
    input  logic              drain_mode,
    output ctx_t              act_ctx,
    output logic [FILL_W-1:0] fill,
    output logic              drop
);
    typedef struct packed {
        ctx_t              head;
        ctx_t              next;
        logic [FILL_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        drop = 1'b0;
        // pop (or flush) is resolved before the push
        if (flush) begin
            st_d.cnt = '0;
        end else if (eos && st_q.cnt != '0) begin
            if (st_q.cnt == FILL_W'(2)) begin
                st_d.head = st_q.next;
                st_d.cnt  = FILL_W'(1);
            end else if (drain_mode) begin
                st_d.cnt = '0;
            end
        end
        if (wr_en) begin
            case (st_d.cnt)
                FILL_W'(0): begin
                    st_d.head = wr_ctx;
                    st_d.cnt  = FILL_W'(1);
                end
                FILL_W'(1): begin
                    st_d.next = wr_ctx;
                    st_d.cnt  = FILL_W'(2);
                end
                default: drop = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_ctx = st_q.head;
    assign fill    = st_q.cnt;

    always_comb begin
        if (rst_n) begin
            assert (st_q.cnt <= FILL_W'(2))
                else $error("p_fill_bound_r5: fill count beyond two");
        end
    end
endmodule

// File: rtl/ictx_ovf.sv
module ictx_ovf (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set) begin
            flag_d = 1'b1;
        end else if (clr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q & ie;

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set && clr) |=> flag_q);
endmodule

// File: rtl/inj_ctx_queue.sv
module inj_ctx_queue
    import ictx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTX_W-1:0]  wr_data,
    input  logic              eos,
    input  logic              flush,
    input  logic              drain_mode,
    input  logic              ovf_clr,
    input  logic              ovf_ie,
    output logic              act_valid,
    output logic [EDGE_W-1:0] act_edge,
    output logic [SRC_W-1:0]  act_src,
    output logic [LEN_W-1:0]  act_len,
    output logic [CHAN_W-1:0] act_chan,
    output logic              ovf_flag,
    output logic              ovf_irq
);
    ctx_t              act_ctx;
    logic [FILL_W-1:0] fill;
    logic              drop;

    ictx_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_ctx     (ctx_t'(wr_data)),
        .eos        (eos),
        .flush      (flush),
        .drain_mode (drain_mode),
        .act_ctx    (act_ctx),
        .fill       (fill),
        .drop       (drop)
    );

    ictx_ovf u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (drop),
        .clr   (ovf_clr),
        .ie    (ovf_ie),
        .flag  (ovf_flag),
        .irq   (ovf_irq)
    );

    assign act_valid = (fill != '0);
    assign act_edge  = act_ctx.edge_sel;
    assign act_src   = act_ctx.src;
    assign act_len   = act_ctx.len;
    assign act_chan  = act_ctx.chan;

    p_first_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && fill == '0) |=>
            (act_valid && {act_chan, act_len, act_src, act_edge} == $past(wr_data)));
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && !eos && fill == FILL_W'(2)) |=>
            (ovf_flag && $stable({act_chan, act_len, act_src, act_edge})));
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain_mode && eos && !flush && !wr_en && fill == FILL_W'(1)) |=>
            (act_valid && $stable({act_chan, act_len, act_src, act_edge})));
    p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_mode && eos && !flush && !wr_en && fill == FILL_W'(1)) |=> !act_valid);
    p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !wr_en) |=> !act_valid);
endmodule

// File: tb/inj_ctx_queue_tb.sv
module inj_ctx_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [27:0] wr_data = '0;
    logic        eos = 1'b0;
    logic        flush = 1'b0;
    logic        drain_mode = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        ovf_ie = 1'b1;
    logic        act_valid;
    logic [1:0]  act_edge;
    logic [3:0]  act_src;
    logic [1:0]  act_len;
    logic [19:0] act_chan;
    logic        ovf_flag;
    logic        ovf_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    inj_ctx_queue u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .eos(eos),
        .flush(flush), .drain_mode(drain_mode), .ovf_clr(ovf_clr), .ovf_ie(ovf_ie),
        .act_valid(act_valid), .act_edge(act_edge), .act_src(act_src),
        .act_len(act_len), .act_chan(act_chan), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    wire [27:0] act_word = {act_chan, act_len, act_src, act_edge};

    // behavioural reference: a queue of words plus a sticky bit
    logic [27:0] mq[$];
    logic [27:0] m_last;
    bit          m_flag;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_flag = 1'b0;
        end else begin
            bit ovf;
            ovf = 1'b0;
            if (flush) mq.delete();
            else if (eos && mq.size() > 0) begin
                if (mq.size() == 2 || drain_mode) void'(mq.pop_front());
            end
            if (wr_en) begin
                if (mq.size() < 2) mq.push_back(wr_data);
                else ovf = 1'b1;
            end
            if (ovf) m_flag = 1'b1;
            else if (ovf_clr) m_flag = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R3 act_valid", 32'(act_valid), 32'(mq.size() > 0));
            if (mq.size() > 0) chk("R4 active word", 32'(act_word), 32'(mq[0]));
            chk("R7 ovf_flag", 32'(ovf_flag), 32'(m_flag));
            chk("R8 ovf_irq", 32'(ovf_irq), 32'(m_flag && ovf_ie));
        end
    end

    task automatic cyc(input bit w, input logic [27:0] d, input bit e,
                       input bit f, input bit c);
        wr_en = w; wr_data = d; eos = e; flush = f; ovf_clr = c;
        @(negedge clk);
        wr_en = 1'b0; eos = 1'b0; flush = 1'b0; ovf_clr = 1'b0;
    endtask

    localparam logic [27:0] A = 28'h1234567, B = 28'h89ABCDE, C = 28'h0F0F0F1,
                            D = 28'h5A5A5A5, E = 28'h3C3C3C3, F = 28'h7777777,
                            G = 28'h2468ACE, H = {5'd19, 5'd7, 5'd30, 5'd2, 2'd3, 4'd9, 2'd1};

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 act_valid", 32'(act_valid), 0);
        chk("R2 ovf_flag", 32'(ovf_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 empty after release", 32'(act_valid), 0);
        cyc(1, A, 0, 0, 0);
        chk("R3 valid", 32'(act_valid), 1);
        chk("R3 word", 32'(act_word), 32'(A));
        cyc(1, B, 0, 0, 0);
        chk("R4 active unchanged", 32'(act_word), 32'(A));
        cyc(1, C, 0, 0, 0);
        chk("R5 dropped", 32'(act_word), 32'(A));
        chk("R5 flag", 32'(ovf_flag), 1);
        chk("R8 irq", 32'(ovf_irq), 1);
        cyc(0, 0, 0, 0, 1);
        chk("R7 cleared", 32'(ovf_flag), 0);
        cyc(0, 0, 1, 0, 0);
        chk("R4 pending active", 32'(act_word), 32'(B));
        cyc(0, 0, 1, 0, 0);
        chk("R5 dropped word never seen", 32'(act_word), 32'(B));
        chk("R9 kept", 32'(act_valid), 1);
        cyc(1, C, 0, 0, 0);
        cyc(1, D, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(1, E, 1, 0, 0);
        chk("R6 no overflow", 32'(ovf_flag), 0);
        chk("R6 popped", 32'(act_word), 32'(C));
        cyc(0, 0, 1, 0, 0);
        chk("R6 write stored", 32'(act_word), 32'(E));
        cyc(1, F, 0, 0, 0);
        cyc(1, G, 0, 0, 1);
        chk("R7 set wins", 32'(ovf_flag), 1);
        ovf_ie = 1'b0;
        @(negedge clk);
        chk("R8 irq masked", 32'(ovf_irq), 0);
        ovf_ie = 1'b1;
        cyc(0, 0, 0, 1, 1);
        chk("R11 flushed", 32'(act_valid), 0);
        cyc(1, H, 0, 1, 0);
        chk("R11 write with flush", 32'(act_valid), 1);
        chk("R11 word", 32'(act_word), 32'(H));
        chk("R1 edge", 32'(act_edge), 1);
        chk("R1 src", 32'(act_src), 9);
        chk("R1 len", 32'(act_len), 3);
        chk("R1 ch1", 32'(act_chan[9:5]), 30);
        chk("R1 ch3", 32'(act_chan[19:15]), 19);
        drain_mode = 1'b1;
        cyc(0, 0, 1, 0, 0);
        chk("R10 drained", 32'(act_valid), 0);
        cyc(0, 0, 1, 0, 0);
        chk("R10 stays empty", 32'(act_valid), 0);
        for (int i = 0; i < 4000; i++) begin
            wr_en      = ($urandom % 3) == 0;
            wr_data    = 28'($urandom);
            eos        = ($urandom % 3) == 0;
            flush      = ($urandom % 40) == 0;
            ovf_clr    = ($urandom % 8) == 0;
            ovf_ie     = ($urandom % 4) != 0;
            if (i % 500 == 0) drain_mode = ~drain_mode;
            @(negedge clk);
        end
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 20000) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule